// File: doc/BRIEF.md
# Channel Start-Up and Lock Controller

This block takes one terminal of a multi-ended differential protection scheme from power-on to protection enabled. Every terminal runs its own copy and needs no help from its peers. The terminals may therefore power up in any order, and the line may be live or dead. After reset the block holds the buffer-pointer clear line high. It keeps it high until local initialisation reports done, which covers loading settings and seeding the filter state variables. It then enters start-up, and every channel begins sending the short start-up message that carries a single time-step value.

Each channel leaves start-up on its own. The first message that arrives on a channel puts that channel in service and gives its loop filters a one-cycle start pulse. A failure strobe on an in-service channel returns it to start-up transmission, which is the same treatment it gets during channel recovery. The lock test runs all the time: the lock flag is set while the measured total clock uncertainty is strictly below the threshold. Protection is enabled while the block holds lock and at least `REQ_CH` channels are in service.

Top module: `link_startup_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `buf_ptr_clr` is 1 after that edge and every other output is 0.
- R2: `buf_ptr_clr` stays 1 from reset until `init_done` is sampled high in the init phase. The first edge after reset always moves the block into the init phase and ignores `init_done`. `buf_ptr_clr` is 0 after the edge that samples `init_done`.
- R3: `tx_startup_fmt` is all zero while `buf_ptr_clr` is 1. It becomes 1 on every channel not in service one edge after `buf_ptr_clr` falls.
- R4: `msg_arrive` has no effect on a channel before its start-up transmission begins, so `chan_live` stays 0.
- R5: A `msg_arrive` bit sampled while that channel is in start-up makes the channel's `chan_live` 1, its `tx_startup_fmt` 0 and its `filt_start` 1 after that edge.
- R6: Channels enter service independently, in any order. Bit i of every per-channel port belongs to channel i.
- R7: `filt_start` is high for exactly one cycle per entry into service. Further arrivals on an in-service channel give no pulse.
- R8: A `chan_fail` bit sampled on an in-service channel makes its `chan_live` 0 and its `tx_startup_fmt` 1 after that edge, and it wins over a same-cycle `msg_arrive`. On a channel that is in start-up, `chan_fail` has no effect.
- R9: `lock_ok` is 1 one edge after the block samples `clk_uncert < uncert_limit` (strictly less) once start-up has begun. It is 0 during the reset and init phases and whenever the comparison fails.
- R10: `prot_en` becomes 1 one edge after `lock_ok` is 1 while at least `REQ_CH` (default 2) channels are in service.
- R11: `prot_en` returns to 0 one edge after `lock_ok` falls or after the in-service count drops below `REQ_CH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_done | input | 1 | Local initialisation finished |
| msg_arrive | input | NUM_CH | Per-channel incoming message strobe |
| chan_fail | input | NUM_CH | Per-channel failure strobe |
| clk_uncert | input | UNC_W | Measured total clock uncertainty |
| uncert_limit | input | UNC_W | Lock threshold |
| buf_ptr_clr | output | 1 | Hold buffer pointers in reset |
| tx_startup_fmt | output | NUM_CH | Channel sends start-up messages |
| chan_live | output | NUM_CH | Channel in service |
| filt_start | output | NUM_CH | One-cycle loop filter start pulse |
| lock_ok | output | 1 | Clock uncertainty under threshold |
| prot_en | output | 1 | Differential protection enabled |

## Verification
A strobe or comparison reaches the channel and lock outputs after one edge. Start-up transmission follows two edges after `init_done` is sampled, and `prot_en` follows one edge after the registered lock or in-service condition. The bench drives every input away from the rising edge and advances one edge at a time. After each edge it compares every affected output against the value the requirements predict for exactly that cycle. It also checks the cycle in which a result must not yet have appeared, such as `prot_en` still being high one edge after a failure.

// File: rtl/lsc_pkg.sv
// Shared types for the channel start-up and lock controller.
// Assumes: nothing beyond IEEE 1800-2017.
package lsc_pkg;

    // Terminal-level sequence.
    typedef enum logic [1:0] {
        TS_RESET   = 2'd0,
        TS_INIT    = 2'd1,
        TS_STARTUP = 2'd2,
        TS_RUNNING = 2'd3
    } term_st_t;

    // Per-channel sub-state.
    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_SEEK = 2'd1,
        CH_LIVE = 2'd2
    } chan_st_t;

endpackage

// File: rtl/lsc_seq.sv
// Terminal sequencer: RESET -> INIT -> STARTUP <-> RUNNING.
// Drives the buffer-pointer clear, the channel arm and protection enable.
// Assumes: lock_ok and live_vec are registered outputs of sibling blocks.
module lsc_seq
    import lsc_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int REQ_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_done,
    input  logic              lock_ok,
    input  logic [NUM_CH-1:0] live_vec,
    output logic              buf_ptr_clr,
    output logic              arm,
    output logic              prot_en
);
    localparam int CNT_W = $clog2(NUM_CH + 1);

    term_st_t   st_q, st_nxt;
    logic [CNT_W-1:0] live_cnt;
    logic       enough;

    // Count channels currently in service.
    always_comb begin
        live_cnt = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            live_cnt = live_cnt + CNT_W'(live_vec[i]);
        end
        enough = (live_cnt >= CNT_W'(REQ_CH)) && lock_ok;
    end

    // Next-state decision for the terminal sequence.
    always_comb begin
        st_nxt = st_q;
        case (st_q)
            TS_RESET:   st_nxt = TS_INIT;
            TS_INIT:    if (init_done) st_nxt = TS_STARTUP;
            TS_STARTUP: if (enough) st_nxt = TS_RUNNING;
            TS_RUNNING: if (!enough) st_nxt = TS_STARTUP;
            default:    st_nxt = TS_RESET;
        endcase
    end

    // State and registered outputs decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= TS_RESET;
            buf_ptr_clr <= 1'b1;
            arm         <= 1'b0;
            prot_en     <= 1'b0;
        end else begin
            st_q        <= st_nxt;
            buf_ptr_clr <= (st_nxt == TS_RESET) || (st_nxt == TS_INIT);
            arm         <= (st_nxt == TS_STARTUP) || (st_nxt == TS_RUNNING);
            prot_en     <= (st_nxt == TS_RUNNING);
        end
    end
endmodule

// File: rtl/lsc_chan.sv
// One channel: OFF until armed, SEEK (start-up transmit) until a
// message arrives, LIVE until a failure strobe. Emits a one-cycle filter
// start on each SEEK -> LIVE move. Assumes strobes are one clock wide or
// level; a failure wins over a same-cycle arrival.
module lsc_chan
    import lsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic arrive,
    input  logic fail,
    output logic tx_fmt,
    output logic live,
    output logic filt_start
);
    chan_st_t st_q, st_nxt;

    // Next sub-state for this channel.
    always_comb begin
        st_nxt = st_q;
        if (!arm) begin
            st_nxt = CH_OFF;
        end else begin
            case (st_q)
                CH_OFF:  st_nxt = CH_SEEK;
                CH_SEEK: if (arrive) st_nxt = CH_LIVE;
                CH_LIVE: if (fail) st_nxt = CH_SEEK;
                default: st_nxt = CH_OFF;
            endcase
        end
    end

    // Sub-state and registered per-channel outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= CH_OFF;
            tx_fmt     <= 1'b0;
            live       <= 1'b0;
            filt_start <= 1'b0;
        end else begin
            st_q       <= st_nxt;
            tx_fmt     <= (st_nxt == CH_SEEK);
            live       <= (st_nxt == CH_LIVE);
            filt_start <= (st_nxt == CH_LIVE) && (st_q == CH_SEEK);
        end
    end
endmodule

// File: rtl/lsc_lock.sv
// Lock test: flags lock while the uncertainty is strictly below the
// threshold and the terminal has left init. Re-evaluated every cycle.
// Assumes both values are unsigned in the same units.
module lsc_lock #(
    parameter int UNC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [UNC_W-1:0] unc,
    input  logic [UNC_W-1:0] limit,
    output logic             lock_ok
);
    // Registered threshold comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) lock_ok <= 1'b0;
        else        lock_ok <= arm && (unc < limit);
    end
endmodule

// File: rtl/link_startup_ctrl.sv
// Channel start-up and lock controller top. Wires the terminal
// sequencer, one channel unit per link and the lock test.
// Assumes synchronous active-low reset; all outputs come from registers.
module link_startup_ctrl #(
    parameter int NUM_CH = 3,
    parameter int REQ_CH = 2,
    parameter int UNC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_done,
    input  logic [NUM_CH-1:0] msg_arrive,
    input  logic [NUM_CH-1:0] chan_fail,
    input  logic [UNC_W-1:0]  clk_uncert,
    input  logic [UNC_W-1:0]  uncert_limit,
    output logic              buf_ptr_clr,
    output logic [NUM_CH-1:0] tx_startup_fmt,
    output logic [NUM_CH-1:0] chan_live,
    output logic [NUM_CH-1:0] filt_start,
    output logic              lock_ok,
    output logic              prot_en
);
    logic arm;

    // Terminal-level sequence.
    lsc_seq #(.NUM_CH(NUM_CH), .REQ_CH(REQ_CH)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_done   (init_done),
        .lock_ok     (lock_ok),
        .live_vec    (chan_live),
        .buf_ptr_clr (buf_ptr_clr),
        .arm         (arm),
        .prot_en     (prot_en)
    );

    // One channel unit per link.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        lsc_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .arm        (arm),
            .arrive     (msg_arrive[g]),
            .fail       (chan_fail[g]),
            .tx_fmt     (tx_startup_fmt[g]),
            .live       (chan_live[g]),
            .filt_start (filt_start[g])
        );
    end

    // Clock uncertainty lock test.
    lsc_lock #(.UNC_W(UNC_W)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .unc     (clk_uncert),
        .limit   (uncert_limit),
        .lock_ok (lock_ok)
    );
endmodule

// File: rtl/lsc_checker.sv
// Property checker for link_startup_ctrl, attached with bind below.
module lsc_checker #(
    parameter int NUM_CH = 3,
    parameter int REQ_CH = 2,
    parameter int UNC_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              init_done,
    input logic [NUM_CH-1:0] msg_arrive,
    input logic [NUM_CH-1:0] chan_fail,
    input logic [UNC_W-1:0]  clk_uncert,
    input logic [UNC_W-1:0]  uncert_limit,
    input logic              buf_ptr_clr,
    input logic [NUM_CH-1:0] tx_startup_fmt,
    input logic [NUM_CH-1:0] chan_live,
    input logic [NUM_CH-1:0] filt_start,
    input logic              lock_ok,
    input logic              prot_en
);
    AST_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        buf_ptr_clr |-> (tx_startup_fmt == '0 && chan_live == '0 && !prot_en && !lock_ok)); // R3

    AST_LIVE_NEEDS_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 ((chan_live & ~$past(chan_live) & ~$past(msg_arrive)) == '0)); // R5

    AST_FILT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 ((filt_start & $past(filt_start)) == '0)); // R7

    AST_FILT_WITH_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_start & ~chan_live) == '0); // R5

    AST_LIVE_NOT_STARTUP: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_live & tx_startup_fmt) == '0); // R8

    AST_PROT_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 (prot_en |-> $past(lock_ok))); // R10

    AST_PROT_NEEDS_LINKS: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 (prot_en |-> ($countones($past(chan_live)) >= REQ_CH))); // R11
endmodule

bind link_startup_ctrl lsc_checker #(.NUM_CH(NUM_CH), .REQ_CH(REQ_CH), .UNC_W(UNC_W)) u_lsc_chk (.*);

// File: tb/test_link_startup_ctrl.sv
module test_link_startup_ctrl;
    localparam int NUM_CH = 3;
    localparam int REQ_CH = 2;
    localparam int UNC_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              init_done;
    logic [NUM_CH-1:0] msg_arrive;
    logic [NUM_CH-1:0] chan_fail;
    logic [UNC_W-1:0]  clk_uncert;
    logic [UNC_W-1:0]  uncert_limit;
    logic              buf_ptr_clr;
    logic [NUM_CH-1:0] tx_startup_fmt;
    logic [NUM_CH-1:0] chan_live;
    logic [NUM_CH-1:0] filt_start;
    logic              lock_ok;
    logic              prot_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    link_startup_ctrl #(.NUM_CH(NUM_CH), .REQ_CH(REQ_CH), .UNC_W(UNC_W)) i_link_startup_ctrl (
        .clk(clk), .rst_n(rst_n), .init_done(init_done), .msg_arrive(msg_arrive),
        .chan_fail(chan_fail), .clk_uncert(clk_uncert), .uncert_limit(uncert_limit),
        .buf_ptr_clr(buf_ptr_clr), .tx_startup_fmt(tx_startup_fmt), .chan_live(chan_live),
        .filt_start(filt_start), .lock_ok(lock_ok), .prot_en(prot_en)
    );

    // Advance one rising edge, then settle away from it.
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; init_done = 1'b0; msg_arrive = '0; chan_fail = '0;
        clk_uncert = 16'd100; uncert_limit = 16'd50;
        step(); step();
        chk("R1", "buf_ptr_clr", buf_ptr_clr, 1);
        chk("R1", "tx_startup_fmt", tx_startup_fmt, 0);
        chk("R1", "chan_live", chan_live, 0);
        chk("R1", "filt_start", filt_start, 0);
        chk("R1", "lock_ok", lock_ok, 0);
        chk("R1", "prot_en", prot_en, 0);
    endtask

    task automatic t_init();
        rst_n = 1'b1; init_done = 1'b1; msg_arrive = 3'b111; clk_uncert = 16'd10;
        step(); // first edge: reset phase -> init, init_done ignored
        chk("R2", "clr after first edge", buf_ptr_clr, 1);
        init_done = 1'b0;
        step(); step();
        chk("R2", "clr held in init", buf_ptr_clr, 1);
        chk("R4", "live before start-up", chan_live, 0);
        chk("R3", "no start-up tx in init", tx_startup_fmt, 0);
        chk("R9", "no lock in init", lock_ok, 0);
        msg_arrive = '0; clk_uncert = 16'd100; init_done = 1'b1;
        step();
        chk("R2", "clr after init_done", buf_ptr_clr, 0);
        chk("R3", "tx not yet", tx_startup_fmt, 0);
        init_done = 1'b0;
        step();
        chk("R3", "start-up tx all", tx_startup_fmt, 3'b111);
        chk("R4", "still none live", chan_live, 0);
    endtask

    task automatic t_arrive();
        msg_arrive = 3'b100;
        step();
        chk("R5", "ch2 live", chan_live, 3'b100);
        chk("R5", "ch2 tx off", tx_startup_fmt, 3'b011);
        chk("R5", "ch2 filt pulse", filt_start, 3'b100);
        msg_arrive = '0;
        step();
        chk("R7", "pulse one cycle", filt_start, 0);
        msg_arrive = 3'b100;
        step();
        chk("R7", "no pulse on repeat", filt_start, 0);
        chk("R7", "still live", chan_live, 3'b100);
        msg_arrive = 3'b001;
        step();
        chk("R6", "ch0 after ch2", chan_live, 3'b101);
        chk("R6", "ch0 pulse only", filt_start, 3'b001);
        chk("R6", "ch1 still start-up", tx_startup_fmt, 3'b010);
        msg_arrive = '0;
    endtask

    task automatic t_lock();
        clk_uncert = 16'd50; uncert_limit = 16'd50;
        step();
        chk("R9", "equal is not lock", lock_ok, 0);
        clk_uncert = 16'd49;
        step();
        chk("R9", "below is lock", lock_ok, 1);
        chk("R10", "prot not yet", prot_en, 0);
        step();
        chk("R10", "prot enabled", prot_en, 1);
    endtask

    task automatic t_fail();
        chan_fail = 3'b001; msg_arrive = 3'b001;
        step();
        chk("R8", "ch0 out", chan_live, 3'b100);
        chk("R8", "ch0 back to start-up", tx_startup_fmt, 3'b011);
        chk("R8", "no pulse on fail", filt_start, 0);
        chk("R11", "prot one more cycle", prot_en, 1);
        chan_fail = 3'b010; msg_arrive = '0;
        step();
        chk("R11", "prot dropped, too few", prot_en, 0);
        chk("R8", "fail on start-up ch1 ignored", tx_startup_fmt, 3'b011);
        chk("R8", "live unchanged", chan_live, 3'b100);
        chan_fail = '0; msg_arrive = 3'b001;
        step();
        chk("R5", "ch0 re-enters", filt_start, 3'b001);
        msg_arrive = '0;
        step();
        chk("R10", "prot back", prot_en, 1);
        clk_uncert = 16'd60;
        step();
        chk("R9", "lock lost", lock_ok, 0);
        chk("R11", "prot lags one", prot_en, 1);
        step();
        chk("R11", "prot dropped on lock loss", prot_en, 0);
    endtask

    initial begin
        t_reset();
        t_init();
        t_arrive();
        t_lock();
        t_fail();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule